// File: doc/BRIEF.md
# Write-in-progress status reporter

This block sits between a nonvolatile memory's write sequencer, its array read path and the host read bus. While an internal program cycle runs, it replaces part of the normal read data with completion status. The top data bit carries the complement of the top bit of the last byte loaded. The next bit down flips on every completed host read. A separate ready/busy line is pulled low from the first write strobe until the program cycle ends. When no cycle is running, array data passes through unchanged.

A host can poll for completion in either of two ways. It can read one fixed address until the top bit matches the value it wrote, or until the toggle bit stops changing. It can also watch the ready/busy line. An active-low run enable acts as the memory's protection reset. While it is low, reads are refused, the data bus floats and any pending ready/busy indication is dropped.

Tri-state pins are modelled as a value plus an output enable. The ready/busy pin is open-drain: when enabled it drives zero, and when disabled it is released.

Top module: `wip_status`

## Requirements
- R1: While busy_i is high, a granted read returns rd_data_o[DW-1] equal to the complement of last_byte_i[DW-1].
- R2: While busy_i is high, rd_data_o[DW-2] inverts after each completed read. A completed read is a low-to-high transition of oe_ni, seen at a clock edge, while ce_ni is low. An oe_ni pulse taken while ce_ni is high leaves the bit unchanged.
- R3: Each program cycle starts the toggle bit at TOG_INIT (0 by default). The first read of every cycle returns rd_data_o[DW-2] = 0.
- R4: The clock edge that samples wr_strobe_i high with run_en_i high drives ready/busy (rb_oe_o = 1, rb_o = 0) from the next cycle on. A strobe sampled while run_en_i is low has no effect.
- R5: rb_oe_o returns to 0 one clock edge after busy_i is sampled low during the program cycle.
- R6: While run_en_i is low, rd_oe_o = 0 and rd_data_o = 0. A driven ready/busy line is released at the next clock edge.
- R7: With busy_i low, a granted read returns array_data_i unchanged in every bit, including the first read after a cycle ends.
- R8: rd_oe_o is 1 only when ce_ni and oe_ni are both low and run_en_i is high. Otherwise rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Protection reset pin, active low; low inhibits reads and writes |
| busy_i | input | 1 | Program cycle active, from the write sequencer |
| wr_strobe_i | input | 1 | Write strobe, from the write sequencer |
| last_byte_i | input | DW | Last byte loaded for programming |
| array_data_i | input | DW | Read data from the array |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_data_o | output | DW | Read data value |
| rd_oe_o | output | 1 | Read data bus output enable |
| rb_o | output | 1 | Ready/busy value when driven (always 0) |
| rb_oe_o | output | 1 | Ready/busy pull-down enable |

## Verification
The bench builds the block with DW = 8 and TOG_INIT = 0. With these values the poll bit is bit 7 and the toggle bit is bit 6, and byte patterns can be chosen so that each of those two bits differs between the array value and the status value. The table mixes idle reads, status reads and inhibited reads. The directed part then runs two complete program cycles. This exposes toggle-bit restart, a strobe taken while protected, a read pulse with the chip deselected, and an abort by the run enable in the middle of a cycle.

// File: rtl/wip_status_pkg.sv
package wip_status_pkg;
  typedef enum logic [1:0] {
    RB_IDLE = 2'd0,
    RB_LOAD = 2'd1,
    RB_PROG = 2'd2
  } rb_state_e;
endpackage

// File: rtl/wip_rd_edge.sv
module wip_rd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic done_o
);
  logic oe_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_prev_q <= 1'b1;
    else         oe_prev_q <= oe_ni;
  end

  // completed read: OE released while chip still selected
  assign done_o = run_en_i && !oe_prev_q && oe_ni && !ce_ni;
endmodule

// File: rtl/wip_toggle.sv
module wip_toggle #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  input  logic busy_i,
  input  logic done_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_q <= TOG_INIT;
    else if (!busy_i || !run_en_i) tog_q <= TOG_INIT;
    else if (done_i)             tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  a_r2_flip_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && run_en_i && done_i) |=> (tog_q != $past(tog_q)));
  a_r2_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && run_en_i && !done_i) |=> (tog_q == $past(tog_q)));
  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (tog_q == TOG_INIT));
endmodule

// File: rtl/wip_rb_ctrl.sv
module wip_rb_ctrl
  import wip_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  input  logic busy_i,
  input  logic wr_strobe_i,
  output logic rb_oe_o
);
  rb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RB_IDLE: if (wr_strobe_i) state_d = RB_LOAD;
      RB_LOAD: if (busy_i)      state_d = RB_PROG;
      RB_PROG: if (!busy_i)     state_d = RB_IDLE;
      default:                  state_d = RB_IDLE;
    endcase
    if (!run_en_i) state_d = RB_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RB_IDLE;
    else         state_q <= state_d;
  end

  assign rb_oe_o = (state_q != RB_IDLE);

  a_r4_pull_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strobe_i && run_en_i) |=> rb_oe_o);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RB_PROG && !busy_i) |=> !rb_oe_o);
  a_r6_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !rb_oe_o);
endmodule

// File: rtl/wip_rd_mux.sv
module wip_rd_mux #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_en_i,
  input  logic          busy_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          tog_i,
  input  logic          last_msb_i,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o
);
  localparam int PollBit = DW - 1;
  localparam int TogBit  = DW - 2;

  logic          grant;
  logic [DW-1:0] status_word;

  assign grant = run_en_i && !ce_ni && !oe_ni;

  always_comb begin
    status_word          = array_data_i;
    status_word[PollBit] = ~last_msb_i;
    status_word[TogBit]  = tog_i;
  end

  assign rd_oe_o   = grant;
  assign rd_data_o = !grant ? '0 : (busy_i ? status_word : array_data_i);

  a_r1_poll_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && busy_i) |-> (rd_data_o[PollBit] != last_msb_i));
  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && !busy_i) |-> (rd_data_o == array_data_i));
  a_r8_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> (rd_data_o == '0));
endmodule

// File: rtl/wip_status.sv
module wip_status #(
  parameter int   DW       = 8,
  parameter logic TOG_INIT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_en_i,
  input  logic          busy_i,
  input  logic          wr_strobe_i,
  input  logic [DW-1:0] last_byte_i,
  input  logic [DW-1:0] array_data_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o,
  output logic          rb_o,
  output logic          rb_oe_o
);
  logic rd_done;
  logic tog;
  logic unused_last;

  assign unused_last = ^last_byte_i[DW-2:0];

  wip_rd_edge u_edge (
    .clk_i, .rst_ni, .run_en_i, .ce_ni, .oe_ni, .done_o(rd_done)
  );

  wip_toggle #(.TOG_INIT(TOG_INIT)) u_tog (
    .clk_i, .rst_ni, .run_en_i, .busy_i, .done_i(rd_done), .tog_o(tog)
  );

  wip_rb_ctrl u_rb (
    .clk_i, .rst_ni, .run_en_i, .busy_i, .wr_strobe_i, .rb_oe_o
  );

  wip_rd_mux #(.DW(DW)) u_mux (
    .clk_i, .rst_ni, .run_en_i, .busy_i, .ce_ni, .oe_ni,
    .tog_i(tog), .last_msb_i(last_byte_i[DW-1]),
    .array_data_i, .rd_data_o, .rd_oe_o
  );

  assign rb_o = 1'b0;

  a_r6_no_read_inhibited: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |-> (!rd_oe_o && rd_data_o == '0));
endmodule

// File: tb/tb_wip_status.sv
module tb_wip_status;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b1, busy = 1'b0, wr = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] last = '0, arr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_oe, rb, rb_oe;
  int            checks = 0, errors = 0;

  always #5 clk = ~clk;

  wip_status #(.DW(DW), .TOG_INIT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en), .busy_i(busy),
    .wr_strobe_i(wr), .last_byte_i(last), .array_data_i(arr),
    .ce_ni(ce_n), .oe_ni(oe_n), .rd_data_o(rd_data), .rd_oe_o(rd_oe),
    .rb_o(rb), .rb_oe_o(rb_oe)
  );

  // {busy, run_en, ce_n, oe_n, arr, last, exp_oe, exp_data}
  localparam int VW = 29;
  localparam int NV = 9;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h00, 1'b1, 8'hA5},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hFF, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h80, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b1, 8'hBF},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h7F, 1'b1, 8'h80},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h55, 8'h00, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'h00, 1'b0, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00, 1'b0, 8'h00},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // completed read: select, sample, release OE with CE low, deselect
  task automatic do_read(output logic [DW-1:0] d, output logic o);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = rd_data; o = rd_oe;
    oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe();
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic          o;
    repeat (3) @(negedge clk);
    chk("R4 reset rb_oe", {8'h00, rb_oe}, {8'h00, 1'b0});
    chk("R8 reset rd_oe", {rd_data, rd_oe}, {8'h00, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {busy, run_en, ce_n, oe_n, arr, last} = VEC[i][VW-1:9];
      @(negedge clk);
      chk($sformatf("R1/R7/R8/R6 vec %0d", i), {rd_data, rd_oe},
          {VEC[i][7:0], VEC[i][8]});
      busy = 1'b0; run_en = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
    end

    // R4: strobe while protected is ignored
    run_en = 1'b0;
    strobe();
    run_en = 1'b1;
    chk("R4 strobe ignored when inhibited", {8'h00, rb_oe}, {8'h00, 1'b0});

    // first program cycle
    last = 8'h9A; arr = 8'h5B;
    strobe();
    busy = 1'b1;
    chk("R4 rb driven after strobe", {7'h00, rb, rb_oe}, {7'h00, 1'b0, 1'b1});
    do_read(d, o);
    chk("R3 first read toggle 0 / R1 poll", {d, o}, {8'h1B, 1'b1});
    do_read(d, o);
    chk("R2 second read toggled", {d, o}, {8'h5B, 1'b1});
    // R2: OE pulse with chip deselected does not advance toggle
    oe_n = 1'b0; @(negedge clk); oe_n = 1'b1; @(negedge clk);
    do_read(d, o);
    chk("R2 deselected pulse ignored", {d, o}, {8'h1B, 1'b1});
    chk("R4 rb held during cycle", {8'h00, rb_oe}, {8'h00, 1'b1});
    busy = 1'b0; arr = 8'hDB;
    @(negedge clk);
    chk("R5 rb released after busy", {8'h00, rb_oe}, {8'h00, 1'b0});
    do_read(d, o);
    chk("R7 first read after cycle true data", {d, o}, {8'hDB, 1'b1});

    // second cycle: toggle restarts
    strobe();
    busy = 1'b1;
    do_read(d, o);
    chk("R3 toggle restarts in new cycle", {d, o}, {8'h1B, 1'b1});

    // abort by protection pin mid cycle
    run_en = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R6 read refused while inhibited", {rd_data, rd_oe}, {8'h00, 1'b0});
    chk("R6 rb released while inhibited", {8'h00, rb_oe}, {8'h00, 1'b0});
    ce_n = 1'b1; oe_n = 1'b1; run_en = 1'b1;
    @(negedge clk);
    do_read(d, o);
    chk("R6 toggle reset after abort", {d, o}, {8'h1B, 1'b1});
    busy = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule